// File: doc/BRIEF.md
# Program/Erase Status Overlay for a Flash Read Path

This block sits on the read data path of a parallel flash model. While the model runs an internal program or erase, the host does not get array data back from a read. It gets a status word instead. Bit 7 is a polling bit. During a program it carries the inverse of the value being written. During an erase it reads low. Bit 6 flips on every new read cycle for as long as the operation runs.

When the operation ends, the data bits need a short time to settle. During that window bits 7 and 6 already show their final values, and the other bits return a fixed placeholder. After the window, reads pass the array word through unchanged.

The bus front end drives the block. It raises the busy input from the end of the write cycle that starts the operation: the fourth cycle for a program, the sixth for an erase. It also supplies the operation kind, bits 7 and 6 of the word being programmed, the raw array word and a read strobe. The read strobe is high for the length of each host read cycle.

Top module: `wr_status_overlay`

## Requirements
- R1: With `op_busy` low and no settling window open, `rd_word` equals `array_word` in every bit.
- R2: While `op_busy` is high and `op_is_erase` is 0 (program), bit 7 of `rd_word` is the inverse of `prog_hi[1]`, which is bit 7 of the word being programmed.
- R3: While `op_busy` is high and `op_is_erase` is 1 (erase), bit 7 of `rd_word` is 0.
- R4: While `op_busy` is high, bit 6 of `rd_word` changes value once per read cycle, that is, once per rising edge of `rd_strobe` sampled on the clock. It does not change on every clock, so holding the strobe high for several cycles gives only one change.
- R5: A read cycle that starts while `op_busy` is low leaves the bit 6 toggle state as it was. The next read during a later busy period continues from the value held before the idle read.
- R6: While `op_busy` is high, every bit of `rd_word` other than 7 and 6 equals the matching bit of parameter `FILL`.
- R7: A settling window opens in the first cycle in which `op_busy` is low after being high, and lasts `SETTLE_CYC` cycles. During the window, bits other than 7 and 6 equal `FILL`. Bits 7 and 6 show their final values: for a program, `prog_hi[1]` and `prog_hi[0]` as captured during the last busy cycle; for an erase, both read 1. Input changes after busy falls do not alter the window's bits 7 and 6.
- R8: If `op_busy` rises again during a settling window, the busy overlay applies at once and the window is abandoned. The next fall of `op_busy` opens a fresh window of the full `SETTLE_CYC` cycles.
- R9: After reset, `rd_word` passes `array_word` through, and the toggle state is 0. The first busy read therefore returns 1 on bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_busy | input | 1 | Internal program or erase in progress |
| op_is_erase | input | 1 | Operation kind: 1 erase, 0 program |
| prog_hi | input | 2 | Bits 7 and 6 of the word being programmed ([1] is bit 7) |
| rd_strobe | input | 1 | High for the length of each host read cycle |
| array_word | input | DW | Raw word from the array |
| rd_word | output | DW | Word returned to the host |

## Verification
The hardest situation to reach is a busy operation that restarts while a settling window is still open. In that case the window counter must be dropped and later reloaded in full. The stimulus drops busy, waits a few cycles into the window, raises busy again for two cycles and then drops it. It then probes the last cycle of the new window and the first cycle after it.

A second awkward point is the toggle under a read strobe held high for several clocks. It is covered by a read that keeps the strobe high for four cycles and checks that bit 6 moves only once.

// File: rtl/wso_pkg.sv
// Shared definitions for the program/erase status overlay.
// Assumes the status bits sit at fixed positions 7 and 6 of the data word.
package wso_pkg;
    localparam int POLL_BIT = 7;   // data-complement polling bit
    localparam int TGL_BIT  = 6;   // alternating toggle bit

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;
endpackage

// File: rtl/wso_toggle.sv
// Toggle bit state for the status overlay.
// Flips once per read cycle, on a sampled rising edge of the read strobe,
// and only while an operation is busy. Assumes rd_strobe is synchronous to clk.
module wso_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd_strobe,
    output logic tgl
);
    logic strb_q;
    logic rd_rise;

    assign rd_rise = rd_strobe & ~strb_q;

    // Track the strobe and advance the toggle on a busy read start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strb_q <= 1'b0;
            tgl    <= 1'b0;
        end else begin
            strb_q <= rd_strobe;
            if (busy && rd_rise)
                tgl <= ~tgl;
        end
    end

    assert_flip_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_rise) |=> (tgl != $past(tgl)));

    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |=> $stable(tgl));

    assert_one_flip_per_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && $past(rd_strobe)) |=> $stable(tgl));
endmodule

// File: rtl/wso_settle.sv
// Settling window timer and final-status capture.
// Opens a window of SETTLE_CYC cycles from the first non-busy cycle after
// a busy period, and holds the operation kind and programmed bits 7:6
// sampled during busy. Assumes SETTLE_CYC >= 1.
module wso_settle
    import wso_pkg::*;
#(
    parameter int SETTLE_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  op_kind_e   kind_in,
    input  logic [1:0] hi_in,
    output logic       settling,
    output op_kind_e   kind_q,
    output logic [1:0] hi_q
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(SETTLE_CYC - 1);

    logic          busy_q;
    logic [CW-1:0] cnt;

    // Count down the remainder of the window; busy cancels it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt    <= '0;
        end else begin
            busy_q <= busy;
            if (busy)
                cnt <= '0;
            else if (busy_q)
                cnt <= RELOAD;
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    // Capture the final status values while the operation runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= OP_PROG;
            hi_q   <= 2'b00;
        end else if (busy) begin
            kind_q <= kind_in;
            hi_q   <= hi_in;
        end
    end

    assign settling = (busy_q & ~busy) | (cnt != '0);

    assert_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && !busy) |=> (cnt == $past(cnt) - 1'b1));

    assert_cancel_on_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (cnt == '0));

    assert_capture_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |=> ($stable(hi_q) && $stable(kind_q)));
endmodule

// File: rtl/wso_mux.sv
// Per-bit output selector for the status overlay.
// Priority: busy status, then settling placeholder, then array pass-through.
module wso_mux
    import wso_pkg::*;
#(
    parameter int             DW   = 16,
    parameter logic [DW-1:0]  FILL = '0
) (
    input  logic          busy,
    input  op_kind_e      kind_now,
    input  logic          prog7_now,
    input  logic          tgl,
    input  logic          settling,
    input  op_kind_e      kind_q,
    input  logic [1:0]    hi_q,
    input  logic [DW-1:0] array_word,
    output logic [DW-1:0] rd_word
);
    logic fin7;
    logic fin6;

    // Final values of the status bits once the operation has ended.
    always_comb begin
        fin7 = (kind_q == OP_ERASE) ? 1'b1 : hi_q[1];
        fin6 = (kind_q == OP_ERASE) ? 1'b1 : hi_q[0];
    end

    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (i == POLL_BIT) begin : g_poll
            assign rd_word[i] = busy     ? ((kind_now == OP_ERASE) ? 1'b0 : ~prog7_now)
                              : settling ? fin7 : array_word[i];
        end else if (i == TGL_BIT) begin : g_tgl
            assign rd_word[i] = busy     ? tgl
                              : settling ? fin6 : array_word[i];
        end else begin : g_data
            assign rd_word[i] = (busy || settling) ? FILL[i] : array_word[i];
        end
    end
endmodule

// File: rtl/wr_status_overlay.sv
// Program/erase status overlay on the flash read path.
// While op_busy is high, reads return polling and toggle status. After busy
// falls, a settling window shows final status with placeholder data. Then
// the array word passes through. Assumes DW >= 8 and that all inputs are
// synchronous to clk.
module wr_status_overlay
    import wso_pkg::*;
#(
    parameter int            DW         = 16,
    parameter int            SETTLE_CYC = 8,
    parameter logic [DW-1:0] FILL       = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_busy,
    input  logic          op_is_erase,
    input  logic [1:0]    prog_hi,
    input  logic          rd_strobe,
    input  logic [DW-1:0] array_word,
    output logic [DW-1:0] rd_word
);
    localparam logic [DW-1:0] STAT_MASK = (DW'(1) << POLL_BIT) | (DW'(1) << TGL_BIT);

    op_kind_e   kind_now;
    op_kind_e   kind_q;
    logic [1:0] hi_q;
    logic       tgl;
    logic       settling;

    assign kind_now = op_kind_e'(op_is_erase);

    wso_toggle u_toggle (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (op_busy),
        .rd_strobe (rd_strobe),
        .tgl       (tgl)
    );

    wso_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (op_busy),
        .kind_in  (kind_now),
        .hi_in    (prog_hi),
        .settling (settling),
        .kind_q   (kind_q),
        .hi_q     (hi_q)
    );

    wso_mux #(.DW(DW), .FILL(FILL)) u_mux (
        .busy       (op_busy),
        .kind_now   (kind_now),
        .prog7_now  (prog_hi[1]),
        .tgl        (tgl),
        .settling   (settling),
        .kind_q     (kind_q),
        .hi_q       (hi_q),
        .array_word (array_word),
        .rd_word    (rd_word)
    );

    assert_idle_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_busy && !settling) |-> (rd_word == array_word));

    assert_prog_inverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy && !op_is_erase) |-> (rd_word[POLL_BIT] == ~prog_hi[1]));

    assert_erase_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy && op_is_erase) |-> (rd_word[POLL_BIT] == 1'b0));

    assert_fill_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy |-> ((rd_word & ~STAT_MASK) == (FILL & ~STAT_MASK)));

    assert_fill_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_busy && settling) |-> ((rd_word & ~STAT_MASK) == (FILL & ~STAT_MASK)));
endmodule

// File: tb/wr_status_overlay_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module wr_status_overlay_tb;
    localparam int          DW   = 16;
    localparam int          S    = 8;
    localparam logic [15:0] FILL = 16'h5A3C;
    localparam logic [15:0] MASK = 16'h00C0;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          op_busy;
    logic          op_is_erase;
    logic [1:0]    prog_hi;
    logic          rd_strobe;
    logic [DW-1:0] array_word;
    logic [DW-1:0] rd_word;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    logic tgl_m;

    always #4 clk = ~clk;

    wr_status_overlay #(.DW(DW), .SETTLE_CYC(S), .FILL(FILL)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_busy    (op_busy),
        .op_is_erase(op_is_erase),
        .prog_hi    (prog_hi),
        .rd_strobe  (rd_strobe),
        .array_word (array_word),
        .rd_word    (rd_word)
    );

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_busy(logic p7, logic er, logic t);
        logic [15:0] w;
        w    = FILL & ~MASK;
        w[7] = er ? 1'b0 : ~p7;
        w[6] = t;
        return w;
    endfunction

    function automatic logic [15:0] exp_settle(logic [1:0] hi, logic er);
        logic [15:0] w;
        w    = FILL & ~MASK;
        w[7] = er ? 1'b1 : hi[1];
        w[6] = er ? 1'b1 : hi[0];
        return w;
    endfunction

    // One read cycle: strobe high one clock, sample, strobe low one clock.
    task automatic rd_cycle(output logic [15:0] w);
        rd_strobe = 1'b1;
        @(negedge clk);
        if (op_busy) tgl_m = ~tgl_m;
        #1 w = rd_word;
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_pass();
        op_busy = 1'b0;
        repeat (S + 2) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; op_busy = 0; op_is_erase = 0; prog_hi = 0;
        rd_strobe = 0; array_word = 16'h1234;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tgl_m = 1'b0;
        @(negedge clk); #1;
        check("R9 reset pass-through", rd_word, 16'h1234);
    endtask

    task automatic t_idle();
        logic [15:0] w;
        array_word = 16'hFFFF; #1;
        check("R1 idle all ones", rd_word, 16'hFFFF);
        array_word = 16'h0F3C;
        rd_cycle(w);
        check("R1 idle read", w, 16'h0F3C);
    endtask

    task automatic t_prog_busy();
        logic [15:0] w;
        array_word = 16'hBEEF; op_is_erase = 0; prog_hi = 2'b10;
        op_busy = 1'b1;
        @(negedge clk);
        rd_cycle(w);
        check("R9 first busy read toggle=1", {15'b0, w[6]}, 16'h0001);
        check("R2 R6 program word", w, exp_busy(1'b1, 1'b0, tgl_m));
        prog_hi = 2'b01;
        rd_cycle(w);
        check("R2 program bit7 low data", w, exp_busy(1'b0, 1'b0, tgl_m));
        wait_pass();
    endtask

    task automatic t_erase_busy();
        logic [15:0] w;
        array_word = 16'h0000; op_is_erase = 1; prog_hi = 2'b00;
        op_busy = 1'b1;
        @(negedge clk);
        rd_cycle(w);
        check("R3 R6 erase word", w, exp_busy(1'b0, 1'b1, tgl_m));
        wait_pass();
    endtask

    task automatic t_toggle_alt();
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] c;
        op_is_erase = 0; prog_hi = 2'b11; op_busy = 1'b1;
        @(negedge clk);
        rd_cycle(a);
        rd_cycle(b);
        check("R4 successive reads differ", {15'b0, a[6] ^ b[6]}, 16'h0001);
        check("R4 toggle value", b, exp_busy(1'b1, 1'b0, tgl_m));
        // Strobe held for four clocks: one read, one flip.
        rd_strobe = 1'b1;
        @(negedge clk);
        tgl_m = ~tgl_m;
        repeat (3) @(negedge clk);
        #1 c = rd_word;
        rd_strobe = 1'b0;
        @(negedge clk);
        check("R4 held strobe single flip", c, exp_busy(1'b1, 1'b0, tgl_m));
        wait_pass();
    endtask

    task automatic t_idle_reads();
        logic [15:0] w;
        array_word = 16'h2468;
        repeat (3) rd_cycle(w);
        check("R5 idle reads pass data", w, 16'h2468);
        op_is_erase = 0; prog_hi = 2'b00; op_busy = 1'b1;
        @(negedge clk);
        rd_cycle(w);
        check("R5 toggle resumes after idle reads", w, exp_busy(1'b0, 1'b0, tgl_m));
    endtask

    task automatic t_settle_prog();
        // Enters with a program busy; prog_hi=10 captured.
        prog_hi = 2'b10; op_is_erase = 0; array_word = 16'hC3C3;
        @(negedge clk);
        op_busy = 1'b0; op_is_erase = 1; prog_hi = 2'b01;
        #1 check("R7 program window opens", rd_word, exp_settle(2'b10, 1'b0));
        for (int k = 1; k < S; k++) begin
            @(negedge clk);
            if (k == S - 1) begin
                #1 check("R7 program window last cycle", rd_word, exp_settle(2'b10, 1'b0));
            end
        end
        @(negedge clk); #1;
        check("R1 window closed", rd_word, 16'hC3C3);
    endtask

    task automatic t_settle_erase();
        logic [15:0] w;
        op_is_erase = 1; prog_hi = 2'b00; array_word = 16'h1111; op_busy = 1'b1;
        @(negedge clk);
        op_busy = 1'b0;
        #1 check("R7 erase window opens", rd_word, exp_settle(2'b00, 1'b1));
        @(negedge clk);
        rd_cycle(w);
        check("R7 erase window read", w, exp_settle(2'b00, 1'b1));
        wait_pass();
        op_busy = 1'b1; op_is_erase = 0; prog_hi = 2'b00;
        @(negedge clk);
        rd_cycle(w);
        check("R5 window read left toggle", w, exp_busy(1'b0, 1'b0, tgl_m));
        wait_pass();
    endtask

    task automatic t_restart();
        op_is_erase = 0; prog_hi = 2'b11; array_word = 16'h7777; op_busy = 1'b1;
        @(negedge clk);
        op_busy = 1'b0;
        repeat (3) @(negedge clk);
        op_busy = 1'b1; prog_hi = 2'b01;
        #1 check("R8 busy overrides window", rd_word, exp_busy(1'b0, 1'b0, tgl_m));
        repeat (2) @(negedge clk);
        op_busy = 1'b0;
        for (int k = 1; k < S; k++) @(negedge clk);
        #1 check("R8 fresh full window", rd_word, exp_settle(2'b01, 1'b0));
        @(negedge clk); #1;
        check("R8 R1 pass after fresh window", rd_word, 16'h7777);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_prog_busy();
        t_erase_busy();
        t_toggle_alt();
        t_idle_reads();
        t_settle_prog();
        t_settle_erase();
        t_restart();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule